// File: doc/BRIEF.md
# Transmit Channel Status and Error Monitor

This block watches eight transmit DMA channels and presents their state to software through a small register interface. It reports three things for each channel. The first is whether the channel's buffers are drained. The second is whether the channel still has requests outstanding. The third, derived from the other two, is whether the channel is idle. Software polls this word after stopping a channel and waits until that channel reads idle.

The block also records protocol violations in a sticky error word. Each channel has a credit counter. Software or the scheduler loads the counter through a credit input, and each completed transfer decrements it. The downstream FIFO may report full while that counter is still non-zero, and this is recorded as a credit mismatch for the channel. An activate command that reaches a channel whose transfer buffer is still occupied is recorded as an overrun for that channel. Two global events are also latched: an internal address error and a short host transfer. A bit is cleared only by writing one to it. A mask register selects which error bits drive the interrupt output.

Top module: `txmon_top`

## Requirements
- R1: At address 0, read data bits 31:24 show `buf_empty[7:0]`, with channel i at bit 24+i.
- R2: At address 0, read data bits 23:16 show the inverse of `req_pend[7:0]`, so that a 1 means no request is pending. Channel i is at bit 16+i.
- R3: At address 0, read data bits 7:0 show channel i as idle at bit i only when its buffers are empty and it has no pending request. All other status bits read 0.
- R4: Each channel's credit counter behaves as follows. It loads `cred_val` when `cred_load` is high. Otherwise it decrements on `xfer_done` and saturates at zero. A load in the same cycle as `xfer_done` wins.
- R5: Error register (address 1) bit i is set one cycle after `fifo_full[i]` is seen while channel i's credit counter is non-zero. It is not set when that counter is zero.
- R6: Error bit 9+i is set one cycle after `act_cmd[i]` is seen while `trb_busy[i]` is high. An activate on a free buffer, or a busy buffer with no activate, sets nothing.
- R7: `addr_err_evt` sets error bit 31 and `short_xfer_evt` sets error bit 30.
- R8: Error bits are sticky. Writing 1 to an error bit clears it. Writing 0 leaves it unchanged. A write to the status address changes nothing.
- R9: When a new event and a clearing write hit the same bit in the same cycle, the bit ends up set. Other bits in that write still clear.
- R10: The mask register at address 2 stores only the defined error positions (bits 31, 30, 16:9 and 7:0). All other bits read 0. `irq` is high exactly when some error bit and its mask bit are both 1.
- R11: After reset, the error word, the mask and all credit counters are zero and `irq` is low. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_empty | input | 8 | Per-channel buffers-drained flag |
| req_pend | input | 8 | Per-channel outstanding-request flag |
| cred_load | input | 8 | Per-channel credit counter load strobe |
| cred_val | input | 64 | Credit load values, channel i in bits 8i+7:8i |
| xfer_done | input | 8 | Per-channel transfer completion (decrements credit) |
| fifo_full | input | 8 | Per-channel downstream FIFO full indication |
| act_cmd | input | 8 | Per-channel activate command strobe |
| trb_busy | input | 8 | Per-channel transfer buffer occupied flag |
| addr_err_evt | input | 1 | Internal memory address error pulse |
| short_xfer_evt | input | 1 | Host delivered fewer dwords than expected |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Masked OR of error bits |

## Verification
The properties take for granted that every event input, every write strobe and the address are stable around the rising edge. They also assume the address stays fixed for a whole cycle. The write-clear property applies only to cycles in which no event arrives, because R9 gives events priority. The bench changes inputs only on the falling edge. It uses event pulses one cycle long and holds the register address steady while a write is active, so every cycle seen by the properties falls inside those assumptions.

// File: rtl/txmon_pkg.sv
package txmon_pkg;

    localparam int NCH    = 8;
    localparam int DW     = 32;
    localparam int AW     = 2;

    typedef enum logic [AW-1:0] {
        RA_STATUS = 2'd0,
        RA_ERROR  = 2'd1,
        RA_MASK   = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    localparam int ST_EMPTY_LSB  = 24;
    localparam int ST_NOPEND_LSB = 16;
    localparam int ST_IDLE_LSB   = 0;

    localparam int ER_CRED_LSB  = 0;
    localparam int ER_ACT_LSB   = 9;
    localparam int ER_SHORT_BIT = 30;
    localparam int ER_ADDR_BIT  = 31;

    typedef struct packed {
        logic           addr_err;
        logic           short_xfer;
        logic [NCH-1:0] act_ovf;
        logic [NCH-1:0] cred_err;
    } err_evt_t;

    function automatic logic [DW-1:0] err_to_word(input err_evt_t e);
        logic [DW-1:0] w;
        w = '0;
        w[ER_CRED_LSB +: NCH] = e.cred_err;
        w[ER_ACT_LSB  +: NCH] = e.act_ovf;
        w[ER_SHORT_BIT]       = e.short_xfer;
        w[ER_ADDR_BIT]        = e.addr_err;
        return w;
    endfunction

    function automatic logic [DW-1:0] err_valid_bits();
        err_evt_t all;
        all = '1;
        return err_to_word(all);
    endfunction

    function automatic logic [DW-1:0] status_to_word(input logic [NCH-1:0] empty,
                                                     input logic [NCH-1:0] pend);
        logic [DW-1:0] w;
        w = '0;
        w[ST_EMPTY_LSB  +: NCH] = empty;
        w[ST_NOPEND_LSB +: NCH] = ~pend;
        w[ST_IDLE_LSB   +: NCH] = empty & ~pend;
        return w;
    endfunction

endpackage

// File: rtl/txmon_credit.sv
module txmon_credit #(
    parameter int CRED_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CRED_W-1:0] load_val,
    input  logic              xfer,
    input  logic              full,
    output logic              mismatch
);
    logic [CRED_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (xfer && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign mismatch = full && (cnt_q != '0);
endmodule

// File: rtl/txmon_errreg.sv
module txmon_errreg
    import txmon_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_word,
    input  logic [DW-1:0] clr_word,
    output logic [DW-1:0] err_q
);
    localparam logic [DW-1:0] VALID = err_valid_bits();

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= ((err_q & ~clr_word) | set_word) & VALID;
        end
    end
endmodule

// File: rtl/txmon_regif.sv
module txmon_regif
    import txmon_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status_word,
    input  logic [DW-1:0] err_q,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] err_clr,
    output logic          irq
);
    localparam logic [DW-1:0] VALID = err_valid_bits();

    reg_addr_e     ra;
    logic [DW-1:0] mask_q;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (we && ra == RA_MASK) begin
            mask_q <= wdata & VALID;
        end
    end

    assign err_clr = (we && ra == RA_ERROR) ? wdata : '0;
    assign irq     = |(err_q & mask_q);

    always_comb begin
        case (ra)
            RA_STATUS: rdata = status_word;
            RA_ERROR:  rdata = err_q;
            RA_MASK:   rdata = mask_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/txmon_top.sv
module txmon_top
    import txmon_pkg::*;
#(
    parameter int CRED_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        buf_empty,
    input  logic [NCH-1:0]        req_pend,
    input  logic [NCH-1:0]        cred_load,
    input  logic [NCH*CRED_W-1:0] cred_val,
    input  logic [NCH-1:0]        xfer_done,
    input  logic [NCH-1:0]        fifo_full,
    input  logic [NCH-1:0]        act_cmd,
    input  logic [NCH-1:0]        trb_busy,
    input  logic                  addr_err_evt,
    input  logic                  short_xfer_evt,
    input  logic [AW-1:0]         reg_addr,
    input  logic                  reg_we,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic                  irq
);
    err_evt_t       evt;
    logic [NCH-1:0] cred_mis;
    logic [DW-1:0]  evt_word;
    logic [DW-1:0]  clr_word;
    logic [DW-1:0]  err_q;
    logic [DW-1:0]  status_word;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        txmon_credit #(.CRED_W(CRED_W)) credit_i (
            .clk      (clk),
            .rst      (rst),
            .load     (cred_load[g]),
            .load_val (cred_val[g*CRED_W +: CRED_W]),
            .xfer     (xfer_done[g]),
            .full     (fifo_full[g]),
            .mismatch (cred_mis[g])
        );
    end

    always_comb begin
        evt.cred_err   = cred_mis;
        evt.act_ovf    = act_cmd & trb_busy;
        evt.short_xfer = short_xfer_evt;
        evt.addr_err   = addr_err_evt;
    end

    assign evt_word    = err_to_word(evt);
    assign status_word = status_to_word(buf_empty, req_pend);

    txmon_errreg errreg_i (
        .clk      (clk),
        .rst      (rst),
        .set_word (evt_word),
        .clr_word (clr_word),
        .err_q    (err_q)
    );

    txmon_regif regif_i (
        .clk         (clk),
        .rst         (rst),
        .addr        (reg_addr),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .status_word (status_word),
        .err_q       (err_q),
        .rdata       (reg_rdata),
        .err_clr     (clr_word),
        .irq         (irq)
    );
endmodule

// File: rtl/txmon_chk.sv
module txmon_chk
    import txmon_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] buf_empty,
    input logic [NCH-1:0] req_pend,
    input logic [AW-1:0]  reg_addr,
    input logic           reg_we,
    input logic [DW-1:0]  reg_wdata,
    input logic [DW-1:0]  reg_rdata,
    input logic           irq,
    input logic [DW-1:0]  err_q,
    input logic [DW-1:0]  evt_word
);
    a_r3_idle_view: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_STATUS) |-> (reg_rdata[NCH-1:0] == (buf_empty & ~req_pend)));

    a_r5_event_latched: assert property (@(posedge clk) disable iff (rst)
        (evt_word != '0) |=> ((err_q & $past(evt_word)) == $past(evt_word)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_ERROR) |=> ((err_q & $past(err_q)) == $past(err_q)));

    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_ERROR && evt_word == '0)
        |=> ((err_q & $past(reg_wdata)) == '0));

    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (err_q != '0));
endmodule

bind txmon_top txmon_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .buf_empty (buf_empty),
    .req_pend  (req_pend),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .err_q     (err_q),
    .evt_word  (evt_word)
);

// File: tb/txmon_top_tb_top.sv
`timescale 1ns/1ps
module txmon_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  buf_empty = '0, req_pend = '0, cred_load = '0, xfer_done = '0;
    logic [7:0]  fifo_full = '0, act_cmd = '0, trb_busy = '0;
    logic [63:0] cred_val = '0;
    logic        addr_err_evt = 1'b0, short_xfer_evt = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    txmon_top dut_i (
        .clk(clk), .rst(rst), .buf_empty(buf_empty), .req_pend(req_pend),
        .cred_load(cred_load), .cred_val(cred_val), .xfer_done(xfer_done),
        .fifo_full(fifo_full), .act_cmd(act_cmd), .trb_busy(trb_busy),
        .addr_err_evt(addr_err_evt), .short_xfer_evt(short_xfer_evt),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  empty;
        logic [7:0]  pend;
        logic [31:0] exp;
    } st_vec_t;

    localparam st_vec_t ST_TAB [6] = '{
        '{8'hFF, 8'h00, 32'hFFFF_00FF},
        '{8'h00, 8'hFF, 32'h0000_0000},
        '{8'hA5, 8'h0F, 32'hA5F0_00A0},
        '{8'h3C, 8'hC3, 32'h3C3C_003C},
        '{8'h01, 8'h01, 32'h01FE_0000},
        '{8'h80, 8'h7F, 32'h8080_0080}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        cyc();
        reg_we    = 1'b0;
    endtask

    task automatic chk_err(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(2'd1, d);
        check(req, d, exp);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R11 reset state
        chk_err("R11 err after reset", 32'h0);
        rd(2'd2, d); check("R11 mask after reset", d, 32'h0);
        check("R11 irq after reset", {31'h0, irq}, 32'h0);
        rd(2'd3, d); check("R11 spare address", d, 32'h0);
        rd(2'd0, d); check("R2 status after reset", d, 32'h00FF_0000);

        // R1 R2 R3 status table
        foreach (ST_TAB[i]) begin
            buf_empty = ST_TAB[i].empty;
            req_pend  = ST_TAB[i].pend;
            rd(2'd0, d);
            check($sformatf("R1 R2 R3 status vec %0d", i), d, ST_TAB[i].exp);
        end
        buf_empty = '0; req_pend = '0;

        // R4 loads: ch2=3, ch0=5
        cred_val = '0;
        cred_val[2*8 +: 8] = 8'd3;
        cred_val[0 +: 8]   = 8'd5;
        cyc(); cred_load = 8'h05; cyc(); cred_load = '0;

        // R5 credit mismatch on ch2
        fifo_full = 8'h04; cyc(); fifo_full = '0;
        chk_err("R5 credit mismatch", 32'h0000_0004);
        check("R10 irq masked off", {31'h0, irq}, 32'h0);

        // R8 write 0 and write to status
        wr(2'd1, 32'h0); chk_err("R8 write zero keeps", 32'h0000_0004);
        wr(2'd0, 32'hFFFF_FFFF); chk_err("R8 status write ignored", 32'h0000_0004);
        wr(2'd1, 32'h0000_0004); chk_err("R8 w1c clears", 32'h0);

        // R4 decrement to zero then saturate
        xfer_done = 8'h04; repeat (4) cyc(); xfer_done = '0;
        fifo_full = 8'h04; cyc(); fifo_full = '0;
        chk_err("R4 R5 zero credit no error", 32'h0);

        // R4 load wins over decrement
        cred_val[2*8 +: 8] = 8'd1;
        cred_load = 8'h04; xfer_done = 8'h04; cyc();
        cred_load = '0; xfer_done = '0;
        fifo_full = 8'h04; cyc(); fifo_full = '0;
        chk_err("R4 load wins", 32'h0000_0004);
        wr(2'd1, 32'h0000_0004);

        // R6 activate overrun
        act_cmd = 8'h20; trb_busy = 8'h20; cyc(); act_cmd = '0; trb_busy = '0;
        chk_err("R6 overrun ch5", 32'h0000_4000);
        act_cmd = 8'h40; trb_busy = 8'h80; cyc(); act_cmd = '0; trb_busy = '0;
        chk_err("R6 no overrun", 32'h0000_4000);
        wr(2'd1, 32'h0000_4000);

        // R7 global events
        addr_err_evt = 1'b1; cyc(); addr_err_evt = 1'b0;
        chk_err("R7 address error", 32'h8000_0000);
        short_xfer_evt = 1'b1; cyc(); short_xfer_evt = 1'b0;
        chk_err("R7 short transfer", 32'hC000_0000);

        // R9 set wins over clear (ch0 credit is 5)
        fifo_full = 8'h01;
        wr(2'd1, 32'h8000_0001);
        fifo_full = '0;
        chk_err("R9 set wins", 32'h4000_0001);

        // R10 mask and irq
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R10 mask valid bits", d, 32'hC001_FEFF);
        check("R10 irq all mask", {31'h0, irq}, 32'h1);
        wr(2'd2, 32'h0000_0002);
        check("R10 irq unmatched mask", {31'h0, irq}, 32'h0);
        wr(2'd2, 32'h4000_0000);
        check("R10 irq matched mask", {31'h0, irq}, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        chk_err("R8 clear all", 32'h0);
        check("R10 irq after clear", {31'h0, irq}, 32'h0);

        // R11 reset clears counters and mask
        fifo_full = 8'h01; cyc(); fifo_full = '0;
        rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
        rd(2'd2, d); check("R11 mask cleared", d, 32'h0);
        chk_err("R11 err cleared", 32'h0);
        fifo_full = 8'h01; cyc(); fifo_full = '0;
        chk_err("R11 credit counter cleared", 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule